// File: doc/BRIEF.md
# Memory Card Status and Interrupt Controller

This block sits on the register side of a banked memory expansion card. It shows the card's condition flags in a read-only status byte, keeps a read/write interrupt enable byte, and drives one level-sensitive interrupt line toward the host. Logic elsewhere on the card produces the conditions and feeds them in as plain inputs. Three of them are short events: page ready, invalid page and generic error. The other three are ongoing states: page flip in progress, write-back in progress and busy.

Events are caught on their rising edge and held as pending flags until the host acknowledges them. The host does this by writing any non-zero byte to a write-only acknowledge register. State conditions are never held. While one is enabled and still active, the interrupt stays asserted, so an acknowledge cannot silence it. A host that does not use interrupts can poll the status byte to find out when a page change has finished and the data window can be used again.

The bus side is a byte-wide port. A write strobe, a small register offset and write data go in. Read data comes back combinationally for the offset presented. Reset is synchronous and active low.

Top module: `mc_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the enable byte reads 0x00, no event flag is pending and `irq` is 0.
- R2: At offset 5 the status byte shows the live state inputs in the same cycle: bit 5 is flip in progress, bit 4 is write-back in progress, bit 0 is busy. Bits 3 and 2 always read 0.
- R3: A low-to-high change on the page-ready, invalid-page or error input sets its pending flag. The flag appears in status bit 7, 6 or 1 in the cycle after the edge. An input that stays high does not set the flag again once it has been cleared.
- R4: A write to offset 6 stores the enable byte. Bits 7, 6, 5, 4, 1 and 0 read back as written and bits 3..2 read as 0. The byte keeps its value when no write to offset 6 occurs.
- R5: `irq` is 1 exactly when an enabled pending event flag exists, or an enabled state input is currently high. Enable bit positions match the status bit positions.
- R6: A write of a non-zero value to offset 7 clears every pending event flag from the next cycle on. A write of zero to offset 7 changes nothing.
- R7: An enabled state condition that is still high keeps `irq` at 1 through and after an acknowledge write.
- R8: If an event edge arrives in the same cycle as a non-zero acknowledge, that event's flag is set, not cleared.
- R9: Reads of offset 7 and of any unmapped offset return 0x00. Writes to offset 5 or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ev_page_ready | input | 1 | Page-ready event |
| ev_bad_page | input | 1 | Invalid-page event |
| ev_fault | input | 1 | Generic error event |
| st_flip | input | 1 | Page flip in progress |
| st_wback | input | 1 | Write-back in progress |
| st_busy | input | 1 | Busy |
| irq | output | 1 | Interrupt request, active high, level |

## Verification
The bench acknowledges while busy is enabled and still high. A design that treated the acknowledge as an unconditional clear of the line would drop `irq` there. It also holds an event input high across an acknowledge. A level-latched design would re-raise the flag, where an edge-latched one stays quiet. It raises an event in the same cycle as an acknowledge, where a design with the wrong priority loses the event. Further checks cover a zero-valued acknowledge, writes to the read-only and unmapped offsets, and the two enable bits that do not exist, because a decoder that is loose about any of these would let the host corrupt state or lose events.

// File: rtl/mc_irq_pkg.sv
// Package: mc_irq_pkg
// Shared register offsets and bit positions for the memory card status and
// interrupt controller. Bit positions are shared by the status byte and the
// enable byte, so a status bit and its enable bit always line up.
package mc_irq_pkg;
    localparam int unsigned REG_AW   = 4;
    localparam int unsigned OFS_STAT = 5;
    localparam int unsigned OFS_EN   = 6;
    localparam int unsigned OFS_ACK  = 7;

    localparam int unsigned BIT_RDY   = 7;
    localparam int unsigned BIT_BAD   = 6;
    localparam int unsigned BIT_FLIP  = 5;
    localparam int unsigned BIT_WBACK = 4;
    localparam int unsigned BIT_FAULT = 1;
    localparam int unsigned BIT_BUSY  = 0;

    // Implemented bits of the enable and status bytes (3..2 unused).
    localparam logic [7:0] IMPL_MASK = 8'hF3;

    // Number of edge-type events.
    localparam int unsigned N_EVT = 3;
endpackage

// File: rtl/mc_evt_latch.sv
// Module: mc_evt_latch
// Catches a rising edge on each of N event inputs and holds it in a pending
// flag until an acknowledge pulse. Assumes inputs are synchronous to clk.
// If an edge and an acknowledge fall in the same cycle, the edge wins, so an
// event that arrives during the acknowledge is not lost.
module mc_evt_latch #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_in,
    input  logic         ack,
    output logic [N-1:0] pend
);
    logic [N-1:0] ev_prev;

    // Previous-sample register used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_prev <= '0;
        else        ev_prev <= ev_in;
    end

    for (genvar g = 0; g < N; g++) begin : g_evt
        logic rise;
        assign rise = ev_in[g] & ~ev_prev[g];

        // Pending flag: set on rising edge, cleared by acknowledge, set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)    pend[g] <= 1'b0;
            else if (rise) pend[g] <= 1'b1;
            else if (ack)  pend[g] <= 1'b0;
        end

        p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_in[g] && !ev_prev[g]) |=> pend[g]);
        p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && !(ev_in[g] && !ev_prev[g])) |=> !pend[g]);
        p_edge_beats_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && ev_in[g] && !ev_prev[g]) |=> pend[g]);
    end
endmodule

// File: rtl/mc_reg_port.sv
// Module: mc_reg_port
// Byte-wide register port. Holds the enable byte and decodes the acknowledge
// write. Returns read data combinationally for the offset presented. Assumes
// the write strobe lasts one cycle per access. The acknowledge output is a
// single-cycle pulse for any non-zero write to the acknowledge offset.
module mc_reg_port
    import mc_irq_pkg::*;
#(
    parameter int unsigned AW = REG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic [7:0]    status,
    output logic [7:0]    rdata,
    output logic [7:0]    en,
    output logic          ack
);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_EN   = AW'(OFS_EN);
    localparam logic [AW-1:0] A_ACK  = AW'(OFS_ACK);

    logic wr_en;
    assign wr_en = wr && (addr == A_EN);

    // Enable byte storage; unused bits are kept at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= 8'h00;
        else if (wr_en) en <= wdata & IMPL_MASK;
    end

    // Acknowledge decode: any non-zero value at the acknowledge offset.
    always_comb ack = wr && (addr == A_ACK) && (wdata != 8'h00);

    // Read multiplexer; acknowledge and unmapped offsets read zero.
    always_comb begin
        unique case (addr)
            A_STAT:  rdata = status;
            A_EN:    rdata = en;
            default: rdata = 8'h00;
        endcase
    end

    p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == A_EN) |=> $stable(en));
    p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en & ~IMPL_MASK) == 8'h00);
    p_ack_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_ACK) |-> (rdata == 8'h00));
endmodule

// File: rtl/mc_irq_ctrl.sv
// Module: mc_irq_ctrl
// Top of the status and interrupt controller. It assembles the status byte
// from latched event flags and live state inputs, and drives a level
// interrupt. The interrupt is the OR of enabled pending events and enabled
// active states. Assumes all condition inputs are synchronous to clk.
module mc_irq_ctrl
    import mc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ev_page_ready,
    input  logic              ev_bad_page,
    input  logic              ev_fault,
    input  logic              st_flip,
    input  logic              st_wback,
    input  logic              st_busy,
    output logic              irq
);
    logic [N_EVT-1:0] ev_vec;
    logic [N_EVT-1:0] pend;
    logic [7:0]       status;
    logic [7:0]       en;
    logic             ack;

    assign ev_vec = {ev_page_ready, ev_bad_page, ev_fault};

    mc_evt_latch #(.N(N_EVT)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_in (ev_vec),
        .ack   (ack),
        .pend  (pend)
    );

    mc_reg_port #(.AW(REG_AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .status (status),
        .rdata  (reg_rdata),
        .en     (en),
        .ack    (ack)
    );

    // Status byte assembly: latched events plus live state inputs.
    always_comb begin
        status            = 8'h00;
        status[BIT_RDY]   = pend[2];
        status[BIT_BAD]   = pend[1];
        status[BIT_FAULT] = pend[0];
        status[BIT_FLIP]  = st_flip;
        status[BIT_WBACK] = st_wback;
        status[BIT_BUSY]  = st_busy;
    end

    // Interrupt line: any enabled condition shown in the status byte.
    always_comb irq = |(status & en);

    p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 8'h00) |-> !irq);
    p_busy_holds_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en[BIT_BUSY] && st_busy) |-> irq);
    p_flip_holds_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en[BIT_FLIP] && st_flip) |-> irq);
    p_gap_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_AW'(OFS_STAT)) |-> (reg_rdata[3:2] == 2'b00));
endmodule

// File: tb/test_mc_irq_ctrl.sv
module test_mc_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ev_page_ready = 1'b0, ev_bad_page = 1'b0, ev_fault = 1'b0;
    logic       st_flip = 1'b0, st_wback = 1'b0, st_busy = 1'b0;
    logic       irq;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 0;

    // Behavioural reference state.
    bit [7:0] m_en;
    bit       m_pr, m_pb, m_pf;   // pending: ready, bad page, fault
    bit       m_lr, m_lb, m_lf;   // last sampled event inputs

    always #10 clk = ~clk;

    mc_irq_ctrl i_mc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_page_ready(ev_page_ready), .ev_bad_page(ev_bad_page), .ev_fault(ev_fault),
        .st_flip(st_flip), .st_wback(st_wback), .st_busy(st_busy), .irq(irq)
    );

    // Reference update at each clock edge from the inputs then present.
    always @(posedge clk) begin
        bit ackw;
        ackw = reg_wr && reg_addr == 4'd7 && reg_wdata != 0;
        if (!rst_n) begin
            m_en = 0; m_pr = 0; m_pb = 0; m_pf = 0; m_lr = 0; m_lb = 0; m_lf = 0;
        end else begin
            if (reg_wr && reg_addr == 4'd6) m_en = reg_wdata & 8'b1111_0011;
            if (ev_page_ready && !m_lr) m_pr = 1; else if (ackw) m_pr = 0;
            if (ev_bad_page   && !m_lb) m_pb = 1; else if (ackw) m_pb = 0;
            if (ev_fault      && !m_lf) m_pf = 1; else if (ackw) m_pf = 0;
            m_lr = ev_page_ready; m_lb = ev_bad_page; m_lf = ev_fault;
        end
    end

    function automatic bit [7:0] exp_status();
        return {m_pr, m_pb, st_flip, st_wback, 2'b00, m_pf, st_busy};
    endfunction

    function automatic bit [7:0] exp_rd();
        if (reg_addr == 4'd5) return exp_status();
        if (reg_addr == 4'd6) return m_en;
        return 8'h00;
    endfunction

    // One cycle: wait past the edge, compare, then apply the next inputs.
    task automatic cyc();
        bit [7:0] er;
        bit       ei;
        @(posedge clk); #4;
        er = exp_rd();
        ei = |(exp_status() & m_en);
        n_vec++;
        if (reg_rdata !== er || irq !== ei) begin
            n_bad++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b (addr=%0d)",
                     tag, reg_rdata, irq, er, ei, reg_addr);
        end
    endtask

    task automatic wr(input bit [3:0] a, input bit [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(input bit [3:0] a, input int n);
        reg_addr = a;
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        // R1: reset state, with conditions active while reset is held
        tag = "R1";
        st_busy = 1; ev_fault = 1;
        rd(4'd6, 2); rd(4'd5, 2);
        rst_n = 1;
        rd(4'd6, 1); rd(4'd5, 2);
        ev_fault = 0; st_busy = 0; rd(4'd5, 1);
        wr(4'd7, 8'h01); rd(4'd5, 1);

        // R4: enable write/readback, unused bits zero, hold without write
        tag = "R4";
        wr(4'd6, 8'hFF); rd(4'd6, 2);
        wr(4'd6, 8'h0C); rd(4'd6, 1);
        wr(4'd6, 8'h00); rd(4'd6, 1);

        // R2: live state bits in status
        tag = "R2";
        reg_addr = 4'd5;
        st_flip = 1; cyc(); st_wback = 1; cyc(); st_busy = 1; cyc();
        st_flip = 0; cyc(); st_wback = 0; st_busy = 0; cyc();

        // R3: rising edges latch; staying high does not re-latch after clear
        tag = "R3";
        ev_page_ready = 1; cyc(); ev_page_ready = 0; rd(4'd5, 2);
        ev_bad_page = 1; rd(4'd5, 2); ev_bad_page = 0; rd(4'd5, 1);
        ev_fault = 1; rd(4'd5, 1);
        wr(4'd7, 8'h80); rd(4'd5, 3);
        ev_fault = 0; rd(4'd5, 1);

        // R5: interrupt from enabled events and states only
        tag = "R5";
        wr(4'd7, 8'hFF); rd(4'd5, 1);
        wr(4'd6, 8'h40); ev_page_ready = 1; rd(4'd5, 2); ev_page_ready = 0;
        ev_bad_page = 1; rd(4'd5, 2); ev_bad_page = 0;
        st_wback = 1; rd(4'd5, 1);
        wr(4'd6, 8'h10); rd(4'd5, 2); st_wback = 0; rd(4'd5, 1);
        wr(4'd6, 8'h82); rd(4'd5, 1);
        ev_fault = 1; rd(4'd5, 2); ev_fault = 0;

        // R6: zero acknowledge ignored, non-zero acknowledge clears
        tag = "R6";
        wr(4'd7, 8'h00); rd(4'd5, 2);
        wr(4'd7, 8'h04); rd(4'd5, 2);

        // R7: enabled busy and flip hold the line through an acknowledge
        tag = "R7";
        wr(4'd6, 8'hF3);
        st_busy = 1; ev_page_ready = 1; rd(4'd5, 2); ev_page_ready = 0;
        wr(4'd7, 8'h55); rd(4'd5, 2);
        st_busy = 0; rd(4'd5, 1);
        st_flip = 1; wr(4'd7, 8'h01); rd(4'd5, 2); st_flip = 0; rd(4'd5, 1);

        // R8: an edge in the acknowledge cycle survives
        tag = "R8";
        ev_bad_page = 1; wr(4'd7, 8'h20); rd(4'd5, 2); ev_bad_page = 0;
        ev_fault = 1; wr(4'd7, 8'h01); rd(4'd5, 1); ev_fault = 0;
        wr(4'd7, 8'h01); rd(4'd5, 1);

        // R9: acknowledge and unmapped offsets read zero; stray writes ignored
        tag = "R9";
        rd(4'd7, 1); rd(4'd3, 1); rd(4'd15, 1);
        wr(4'd5, 8'h00); rd(4'd6, 1);
        wr(4'd2, 8'h00); wr(4'd14, 8'hFF); rd(4'd6, 1);
        ev_page_ready = 1; cyc(); ev_page_ready = 0;
        wr(4'd5, 8'hFF); wr(4'd0, 8'hFF); rd(4'd5, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule